// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block runs the master side of one I2C bus at byte level. Software writes a command word into a memory-mapped command register. That one word may ask for several steps at once: an address phase, a data byte out, a data byte in and a stop. The block carries out the requested steps one after another, always in that order. Each step becomes one operation on a byte-level bus engine. The sequencer and the engine talk over a request/acknowledge handshake. Bit-level line timing is left to the engine.

A 4-bit state code shows where the sequence stands, and software can read it back in the command/status word. A single data byte register holds the byte to transmit and the byte received. When a step completes, the block sends a one-cycle event to an interrupt block: address/data acknowledged, negative acknowledge, byte received, stop done or stop refused. The interrupt block returns a "receive pending" level, and a new receive is held back while that level is high.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Register writes use `wr_addr` 0 for function control (bit 0 master enable, bit 1 slave enable), 1 for command and 2 for the data byte. A command write replaces only command bits 15:0. `cmd_rd` returns those bits, the bus-busy input in bit 16 and the state code in bits 22:19. All other bits read as zero.
- R2: A command write is ignored unless master enable is set. This also applies when only slave enable is set.
- R3: Command bits are 0 address/start, 1 transmit, 3 receive, 4 receive-last and 5 stop. Bit 2 is stored but has no effect. The steps run in the order start, transmit, receive, stop. The start step also clears the transmit bit, and no separate data byte is sent for it.
- R4: Start enters state 0xA if state bit 3 is set, and state 0x9 otherwise. It sends `buf_rd[7:0]` as the address byte with operation code 1. On acknowledge it raises event bit 0 and enters state 0x8 (active).
- R5: If the address is not acknowledged, the block raises event bit 1 and clears the start and transmit bits. The state stays at 0x9 or 0xA. The remaining steps are not run, and their command bits stay set.
- R6: Transmit shows state 0xC and sends `buf_rd[7:0]` with operation code 2. On acknowledge it raises event bit 0. On a negative acknowledge it raises event bit 1 and then requests end of transfer (code 5). Either way the transmit bit clears and the state returns to 0x8.
- R7: Receive runs only while `rx_pend` is low. If `rx_pend` is high, the receive bits stay set. Receive shows state 0xE and uses operation code 3. The received byte goes into `buf_rd[15:8]` with bits 7:0 cleared, and event bit 2 is raised. If receive-last was set, a NACK operation (code 4) follows. Both receive bits then clear and the state returns to 0x8.
- R8: Stop while state bit 3 is clear raises event bit 4 and issues no operation. Otherwise stop shows state 0xB, issues end of transfer (code 5) and raises event bit 3. In both cases the stop bit clears and the state becomes 0x0.
- R9: A write to the data byte register keeps only its low 8 bits and clears `buf_rd[15:8]`.
- R10: Reset clears the command bits, the state code, the data byte and the enables. It then holds an end-of-transfer request (code 5) to the engine until the engine acknowledges it.
- R11: While a sequence is running, writes to the command and data byte registers are ignored.
- R12: `eng_req` and `eng_op` stay constant until `eng_ack` arrives. Only one operation is outstanding at a time. `ev_out` pulses for one cycle, with at most one bit set per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 function, 1 command, 2 data byte |
| wr_data | input | 32 | Write data |
| cmd_rd | output | 32 | Command/status readback |
| buf_rd | output | 16 | Data byte register readback |
| rx_pend | input | 1 | Receive event still pending in the interrupt block |
| bus_busy | input | 1 | Bus busy indication from the engine |
| eng_req | output | 1 | Operation request to the engine |
| eng_op | output | 3 | Operation code: 1 start, 2 send, 3 receive, 4 NACK, 5 end |
| eng_wdata | output | 8 | Address or data byte for the engine |
| eng_ack | input | 1 | Engine finished the operation (one cycle) |
| eng_nak | input | 1 | With `eng_ack`: the byte was not acknowledged |
| eng_rdata | input | 8 | With `eng_ack`: the byte received |
| ev_out | output | 5 | Event pulses: 0 ack, 1 nak, 2 byte received, 3 stop done, 4 stop refused |

## Verification
The address-phase negative acknowledge and the stop request can both come from the same command word. The bench provokes this by writing start and stop together, from the idle state, while the engine model refuses the address. The check requires three things: only the start operation reaches the engine, only event bit 1 pulses (no stop-done and no stop-refused), and the stop bit is still set afterwards while the state holds 0x9. A companion case writes start, receive and stop while `rx_pend` is high. There, receive is skipped but stop is still carried out, and the receive bit stays set.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    localparam int REG_W    = 32;
    localparam int CMD_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int ST_W     = 4;
    localparam int OP_W     = 3;
    localparam int EV_W     = 5;

    // command bit positions
    localparam int CB_START  = 0;
    localparam int CB_MTX    = 1;
    localparam int CB_MRX    = 3;
    localparam int CB_RXLAST = 4;
    localparam int CB_STOP   = 5;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE    = 4'h0,
        ST_ACTIVE  = 4'h8,
        ST_START   = 4'h9,
        ST_RESTART = 4'hA,
        ST_STOP    = 4'hB,
        ST_TXD     = 4'hC,
        ST_RXACK   = 4'hD,
        ST_RXD     = 4'hE,
        ST_TXACK   = 4'hF
    } seq_state_e;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_SEND  = 3'd2,
        OP_RECV  = 3'd3,
        OP_NACK  = 3'd4,
        OP_END   = 3'd5
    } eng_op_e;

    typedef enum logic [2:0] {
        STEP_NONE, STEP_START, STEP_TX, STEP_TXEND,
        STEP_RX, STEP_NACK, STEP_STOP, STEP_RSTEND
    } step_e;

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_WAIT} phase_e;

    typedef struct packed {
        logic stop_bad;
        logic stop_ok;
        logic rx_done;
        logic tx_nak;
        logic tx_ack;
    } ev_s;

    function automatic logic is_active(input logic [ST_W-1:0] s);
        return s[3];
    endfunction

endpackage

// File: rtl/i2cseq_step_pick.sv
module i2cseq_step_pick
    import i2cseq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             rx_pend,
    output step_e            step
);
    always_comb begin
        if (cmd[CB_START])
            step = STEP_START;
        else if (cmd[CB_MTX])
            step = STEP_TX;
        else if ((cmd[CB_MRX] || cmd[CB_RXLAST]) && !rx_pend)
            step = STEP_RX;
        else if (cmd[CB_STOP])
            step = STEP_STOP;
        else
            step = STEP_NONE;
    end
endmodule

// File: rtl/i2cseq_eng_port.sv
module i2cseq_eng_port
    import i2cseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  eng_op_e           launch_op,
    input  logic [BYTE_W-1:0] launch_data,
    input  logic              eng_ack,
    output logic              eng_req,
    output eng_op_e           eng_op,
    output logic [BYTE_W-1:0] eng_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            eng_req   <= 1'b1;
            eng_op    <= OP_END;
            eng_wdata <= '0;
        end else if (launch) begin
            eng_req   <= 1'b1;
            eng_op    <= launch_op;
            eng_wdata <= launch_data;
        end else if (eng_ack) begin
            eng_req   <= 1'b0;
        end
    end

    // R12: a pending request is held unchanged until the engine answers
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  cmd_rd,
    output logic [2*BYTE_W-1:0] buf_rd,
    input  logic              rx_pend,
    input  logic              bus_busy,
    output logic              eng_req,
    output logic [OP_W-1:0]   eng_op,
    output logic [BYTE_W-1:0] eng_wdata,
    input  logic              eng_ack,
    input  logic              eng_nak,
    input  logic [BYTE_W-1:0] eng_rdata,
    output logic [EV_W-1:0]   ev_out
);
    localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(2);
    localparam int PAD_HI = REG_W - ST_W - 19;

    logic [CMD_W-1:0]    cmd_q;
    logic [ST_W-1:0]     st_q;
    logic [2*BYTE_W-1:0] buf_q;
    logic [1:0]          func_q;
    phase_e              phase_q;
    step_e               step_q;
    ev_s                 ev_q;

    step_e               pick;
    logic                launch;
    eng_op_e             l_op;
    logic [BYTE_W-1:0]   l_data;
    eng_op_e             op_w;

    i2cseq_step_pick u_pick (
        .cmd     (cmd_q),
        .rx_pend (rx_pend),
        .step    (pick)
    );

    i2cseq_eng_port u_port (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_op   (l_op),
        .launch_data (l_data),
        .eng_ack     (eng_ack),
        .eng_req     (eng_req),
        .eng_op      (op_w),
        .eng_wdata   (eng_wdata)
    );

    assign eng_op = op_w;
    assign ev_out = ev_q;
    assign buf_rd = buf_q;
    assign cmd_rd = {{PAD_HI{1'b0}}, st_q, 2'b00, bus_busy, cmd_q};

    // which engine operation, if any, starts this cycle
    always_comb begin
        launch = 1'b0;
        l_op   = OP_NONE;
        l_data = buf_q[BYTE_W-1:0];
        if (phase_q == PH_RUN) begin
            case (pick)
                STEP_START: begin launch = 1'b1; l_op = OP_START; end
                STEP_TX:    begin launch = 1'b1; l_op = OP_SEND;  end
                STEP_RX:    begin launch = 1'b1; l_op = OP_RECV;  end
                STEP_STOP:  if (is_active(st_q)) begin launch = 1'b1; l_op = OP_END; end
                default: ;
            endcase
        end else if (phase_q == PH_WAIT && eng_ack) begin
            if (step_q == STEP_TX && eng_nak) begin
                launch = 1'b1; l_op = OP_END;
            end else if (step_q == STEP_RX && cmd_q[CB_RXLAST]) begin
                launch = 1'b1; l_op = OP_NACK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            st_q    <= ST_IDLE;
            buf_q   <= '0;
            func_q  <= '0;
            phase_q <= PH_WAIT;
            step_q  <= STEP_RSTEND;
            ev_q    <= '0;
        end else begin
            ev_q <= '0;
            if (wr_en && wr_addr == A_FUNC)
                func_q <= wr_data[1:0];
            case (phase_q)
                PH_IDLE: begin
                    if (wr_en && wr_addr == A_CMD && func_q[0]) begin
                        cmd_q   <= wr_data[CMD_W-1:0];
                        phase_q <= PH_RUN;
                    end
                    if (wr_en && wr_addr == A_BYTE)
                        buf_q <= {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]};
                end
                PH_RUN: begin
                    case (pick)
                        STEP_START: begin
                            st_q    <= is_active(st_q) ? ST_RESTART : ST_START;
                            step_q  <= STEP_START;
                            phase_q <= PH_WAIT;
                        end
                        STEP_TX: begin
                            st_q <= ST_TXD; step_q <= STEP_TX; phase_q <= PH_WAIT;
                        end
                        STEP_RX: begin
                            st_q <= ST_RXD; step_q <= STEP_RX; phase_q <= PH_WAIT;
                        end
                        STEP_STOP: begin
                            if (is_active(st_q)) begin
                                st_q <= ST_STOP; step_q <= STEP_STOP; phase_q <= PH_WAIT;
                            end else begin
                                ev_q.stop_bad   <= 1'b1;
                                cmd_q[CB_STOP]  <= 1'b0;
                                st_q            <= ST_IDLE;
                                phase_q         <= PH_IDLE;
                            end
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
                default: begin
                    if (eng_ack) begin
                        case (step_q)
                            STEP_START: begin
                                cmd_q[CB_START] <= 1'b0;
                                cmd_q[CB_MTX]   <= 1'b0;
                                if (eng_nak) begin
                                    ev_q.tx_nak <= 1'b1;
                                    phase_q     <= PH_IDLE;
                                end else begin
                                    ev_q.tx_ack <= 1'b1;
                                    st_q        <= ST_ACTIVE;
                                    phase_q     <= PH_RUN;
                                end
                            end
                            STEP_TX: begin
                                cmd_q[CB_MTX] <= 1'b0;
                                if (eng_nak) begin
                                    ev_q.tx_nak <= 1'b1;
                                    step_q      <= STEP_TXEND;
                                end else begin
                                    ev_q.tx_ack <= 1'b1;
                                    st_q        <= ST_ACTIVE;
                                    phase_q     <= PH_RUN;
                                end
                            end
                            STEP_RX: begin
                                buf_q        <= {eng_rdata, {BYTE_W{1'b0}}};
                                ev_q.rx_done <= 1'b1;
                                if (cmd_q[CB_RXLAST]) begin
                                    step_q <= STEP_NACK;
                                end else begin
                                    cmd_q[CB_MRX] <= 1'b0;
                                    st_q          <= ST_ACTIVE;
                                    phase_q       <= PH_RUN;
                                end
                            end
                            STEP_NACK: begin
                                cmd_q[CB_MRX]    <= 1'b0;
                                cmd_q[CB_RXLAST] <= 1'b0;
                                st_q             <= ST_ACTIVE;
                                phase_q          <= PH_RUN;
                            end
                            STEP_TXEND: begin
                                st_q    <= ST_ACTIVE;
                                phase_q <= PH_RUN;
                            end
                            STEP_STOP: begin
                                cmd_q[CB_STOP] <= 1'b0;
                                ev_q.stop_ok   <= 1'b1;
                                st_q           <= ST_IDLE;
                                phase_q        <= PH_IDLE;
                            end
                            default: phase_q <= PH_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // R2: with master enable clear, a command write does not start a sequence
    assert_disabled_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && wr_en && wr_addr == A_CMD && !func_q[0]) |=> (phase_q == PH_IDLE));
    // R4: an acknowledge event is always accompanied by the active state
    assert_ack_active_R4: assert property (@(posedge clk) disable iff (rst)
        ev_q.tx_ack |-> (st_q == ST_ACTIVE));
    // R7: a received byte lands in the upper half, lower half cleared
    assert_rx_buf_R7: assert property (@(posedge clk) disable iff (rst)
        ev_q.rx_done |-> (buf_q[BYTE_W-1:0] == '0));
    // R8: both stop outcomes leave the state idle
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (ev_q.stop_ok || ev_q.stop_bad) |-> (st_q == ST_IDLE));
    // R12: never more than one event in a cycle
    assert_one_event_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev_q));
    // R11: no register change of the command bits during a running sequence from writes
    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT && !eng_ack) |=> ($stable(cmd_q) && $stable(buf_q)));
endmodule

// File: tb/sim_i2c_cmd_seq.sv
module sim_i2c_cmd_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_rd;
    logic [15:0] buf_rd;
    logic        rx_pend = 1'b0;
    logic        bus_busy = 1'b0;
    logic        eng_req;
    logic [2:0]  eng_op;
    logic [7:0]  eng_wdata;
    logic        eng_ack = 1'b0;
    logic        eng_nak = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic [4:0]  ev_out;

    always #5 clk = ~clk;

    i2c_cmd_seq u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_rd(cmd_rd), .buf_rd(buf_rd), .rx_pend(rx_pend), .bus_busy(bus_busy),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_ack(eng_ack), .eng_nak(eng_nak), .eng_rdata(eng_rdata), .ev_out(ev_out)
    );

    int checks = 0;
    int fails  = 0;

    // engine model configuration and log
    int         lat = 2;
    logic       nak_a = 1'b0;
    logic       nak_d = 1'b0;
    logic [7:0] rx_byte = '0;
    int         cnt = 0;
    int         opcnt = 0;
    logic [11:0] oplog = '0;
    logic [7:0]  first_wd = '0;
    logic [4:0]  ev_acc = '0;
    int          ev_multi = 0;

    always @(negedge clk) begin
        if (rst) begin
            cnt = 0; eng_ack = 1'b0; eng_nak = 1'b0;
        end else begin
            ev_acc = ev_acc | ev_out;
            if ($countones(ev_out) > 1) ev_multi++;
            if (eng_ack) begin
                eng_ack = 1'b0; eng_nak = 1'b0;
            end else if (eng_req) begin
                if (cnt >= lat) begin
                    eng_ack   = 1'b1;
                    eng_nak   = (eng_op == 3'd1 && nak_a) || (eng_op == 3'd2 && nak_d);
                    eng_rdata = rx_byte;
                    if (opcnt == 0) first_wd = eng_wdata;
                    if (opcnt < 4) oplog[opcnt*3 +: 3] = eng_op;
                    opcnt++;
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_log();
        opcnt = 0; oplog = '0; first_wd = '0; ev_acc = '0;
    endtask

    task automatic wait_op(input logic [2:0] op);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (eng_req && eng_op == op && !eng_ack) return;
        end
    endtask

    typedef struct packed {
        logic [5:0]  cmd;
        logic [7:0]  txb;
        logic        na;
        logic        nd;
        logic        pend;
        logic [7:0]  rdat;
        logic [11:0] ops;
        logic [4:0]  ev;
        logic [5:0]  low;
        logic [3:0]  st;
        logic [15:0] bufv;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{6'h03, 8'hA0, 1'b0, 1'b0, 1'b0, 8'h00, 12'h001, 5'h01, 6'h00, 4'h8, 16'h00A0},
        '{6'h02, 8'h5A, 1'b0, 1'b0, 1'b0, 8'h00, 12'h002, 5'h01, 6'h00, 4'h8, 16'h005A},
        '{6'h08, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3C, 12'h003, 5'h04, 6'h00, 4'h8, 16'h3C00},
        '{6'h30, 8'h00, 1'b0, 1'b0, 1'b0, 8'h77, 12'h163, 5'h0C, 6'h00, 4'h0, 16'h7700},
        '{6'h20, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 12'h000, 5'h10, 6'h00, 4'h0, 16'h0000},
        '{6'h21, 8'h42, 1'b1, 1'b0, 1'b0, 8'h00, 12'h001, 5'h02, 6'h20, 4'h9, 16'h0042},
        '{6'h01, 8'h50, 1'b0, 1'b0, 1'b0, 8'h00, 12'h001, 5'h01, 6'h00, 4'h8, 16'h0050},
        '{6'h22, 8'h99, 1'b0, 1'b1, 1'b0, 8'h00, 12'h16A, 5'h0A, 6'h00, 4'h0, 16'h0099},
        '{6'h2B, 8'h11, 1'b0, 1'b0, 1'b0, 8'hC3, 12'h159, 5'h0D, 6'h00, 4'h0, 16'hC300},
        '{6'h29, 8'h20, 1'b0, 1'b0, 1'b1, 8'h00, 12'h029, 5'h09, 6'h08, 4'h0, 16'h0020}
    };

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clr_log();
        // R10: reset state and end-of-transfer request
        chk("R10 cmd after reset", cmd_rd, 32'h0);
        chk("R10 buf after reset", {16'h0, buf_rd}, 32'h0);
        chk("R10 end request", {28'h0, eng_req, eng_op}, {28'h0, 1'b1, 3'd5});
        repeat (10) @(negedge clk);
        chk("R10 one end op", {oplog, 20'(opcnt)}, {12'h005, 20'd1});

        // R2: disabled and slave-only cannot start
        clr_log();
        wr(2'd1, 32'h0000_0001);
        repeat (10) @(negedge clk);
        chk("R2 disabled no op", {cmd_rd[5:0], 26'(opcnt)}, 32'h0);
        wr(2'd0, 32'h2);
        wr(2'd1, 32'h0000_0021);
        repeat (10) @(negedge clk);
        chk("R2 slave-only no op", {cmd_rd[5:0], 26'(opcnt)}, 32'h0);
        wr(2'd0, 32'h1);

        // R1 busy bit, R9 byte write masking
        bus_busy = 1'b1;
        @(negedge clk);
        chk("R1 busy bit set", {31'h0, cmd_rd[16]}, 32'h1);
        bus_busy = 1'b0;
        @(negedge clk);
        chk("R1 busy bit clear", {31'h0, cmd_rd[16]}, 32'h0);
        wr(2'd2, 32'hFFFF_12AB);
        chk("R9 byte low only", {16'h0, buf_rd}, 32'h0000_00AB);

        // table walk: R3 R4 R5 R6 R7 R8
        foreach (VEC[k]) begin
            nak_a = VEC[k].na; nak_d = VEC[k].nd; rx_pend = VEC[k].pend;
            rx_byte = VEC[k].rdat;
            clr_log();
            wr(2'd2, {24'h0, VEC[k].txb});
            wr(2'd1, {16'hFF00, 10'h0, VEC[k].cmd});
            repeat (40) @(negedge clk);
            chk($sformatf("R3 vec%0d op order", k), {20'h0, oplog}, {20'h0, VEC[k].ops});
            chk($sformatf("R5 vec%0d events", k), {27'h0, ev_acc}, {27'h0, VEC[k].ev});
            chk($sformatf("R8 vec%0d state", k), {28'h0, cmd_rd[22:19]}, {28'h0, VEC[k].st});
            chk($sformatf("R7 vec%0d cmd bits", k), {26'h0, cmd_rd[5:0]}, {26'h0, VEC[k].low});
            chk($sformatf("R1 vec%0d upper cmd", k), {cmd_rd[31:23], cmd_rd[18:17], cmd_rd[15:6]}, 21'h0);
            chk($sformatf("R7 vec%0d buffer", k), {16'h0, buf_rd}, {16'h0, VEC[k].bufv});
            if (VEC[k].ops[2:0] == 3'd1 || VEC[k].ops[2:0] == 3'd2)
                chk($sformatf("R6 vec%0d byte sent", k), {24'h0, first_wd}, {24'h0, VEC[k].txb});
        end
        nak_a = 1'b0; nak_d = 1'b0; rx_pend = 1'b0;

        // mid-sequence state codes, R11 ignored writes, R12 held request
        lat = 8; rx_byte = 8'h5D;
        clr_log();
        wr(2'd2, 32'h11);
        wr(2'd1, 32'h2B);
        wait_op(3'd1);
        chk("R4 state during start", {28'h0, cmd_rd[22:19]}, 32'h9);
        wr(2'd2, 32'hEE);
        wr(2'd1, 32'h20);
        chk("R12 request held", {28'h0, eng_req, eng_op}, {28'h0, 1'b1, 3'd1});
        wait_op(3'd3);
        chk("R7 state during receive", {28'h0, cmd_rd[22:19]}, 32'hE);
        wait_op(3'd5);
        chk("R8 state during stop", {28'h0, cmd_rd[22:19]}, 32'hB);
        repeat (40) @(negedge clk);
        chk("R11 writes ignored buffer", {16'h0, buf_rd}, 32'h5D00);
        chk("R11 writes ignored ops", {20'h0, oplog}, 32'h159);
        chk("R12 single events", ev_multi, 0);

        // R6 transmit state code
        clr_log();
        wr(2'd2, 32'h33);
        wr(2'd1, 32'h01);
        repeat (30) @(negedge clk);
        wr(2'd1, 32'h02);
        wait_op(3'd2);
        chk("R6 state during transmit", {28'h0, cmd_rd[22:19]}, 32'hC);
        repeat (30) @(negedge clk);
        chk("R6 state after transmit", {28'h0, cmd_rd[22:19]}, 32'h8);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule